// File: doc/BRIEF.md
# Page Frame Protection Key Store

This block keeps a small protection key for every 4 KiB frame of installed physical memory. A key holds a 4-bit access-control value in bits 7:4, a fetch-protection flag in bit 3, a referenced flag in bit 2 and a changed flag in bit 1. Bit 0 is not stored and always reads as zero. A processor-side command port supports four operations:
- write the key of one frame;
- read a key back;
- clear the referenced flag;
- a ranged write that walks consecutive frames up to the next 1 MiB boundary.

A second, unacknowledged sideband input reports memory references, so the block can set the referenced and changed flags on its own, apart from any command.

Every key command is privileged and checks its address. A command issued in problem state is refused with a privileged-operation exception. A command whose frame lies beyond installed memory is refused with an addressing exception. A refused command leaves every key as it was. The ranged write returns the address just past the last frame it wrote, so software can repeat it to cover a longer range. Protection checking and the memory data path are handled elsewhere.

Top module: `pgkey_ctrl`

## Requirements
- R1: After reset every key reads as 0x00.
- R2: `cmd_op` 2'b00 (single write) stores `cmd_key[7:1]` into the addressed frame. `cmd_op` 2'b01 (read) returns the stored key on `rsp_key` with bit 0 zero. Key layout: access control in 7:4, fetch protection in 3, referenced in 2, changed in 1.
- R3: A sideband access (`mem_valid`) to an installed frame sets that frame's referenced bit. If `mem_store` is 1 it also sets the changed bit. A sideband access beyond installed memory changes no key.
- R4: After a single write with the changed bit clear, a read returns changed = 0. After one store to that frame, the next read returns changed = 1.
- R5: `cmd_op` 2'b10 clears the referenced bit and returns `rsp_cc` = {referenced, changed} as they were before the command. All other key bits are unchanged.
- R6: `cmd_op` 2'b11 (ranged write) writes `cmd_key[7:1]` to one frame per cycle. It starts at the addressed frame and stops after the last frame of its 1 MiB segment, or after the last installed frame, whichever comes first. `cmd_ready` is low while it runs. Its response gives `rsp_next_addr` = the byte address just past the last frame written, and comes N+1 cycles after acceptance for N frames.
- R7: A command with `cmd_problem` = 1 responds with `rsp_exc` = 2'b01. It changes no key, and its `rsp_key` and `rsp_cc` are zero. This exception takes precedence over the addressing exception.
- R8: In supervisor state, a command whose frame number is NUM_FRAMES or more responds with `rsp_exc` = 2'b10 and changes no key. A ranged write that starts outside installed memory writes no frame and returns `rsp_next_addr` = 0.
- R9: When a command and a sideband access hit the same frame in the same cycle, the sideband marks are applied on top of the command's effect.
- R10: Single-step commands respond with `rsp_valid` in the cycle after acceptance. A read or reference-clear reports the key as it stood before any sideband mark made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | High when a command can be accepted |
| cmd_op | input | 2 | 00 write, 01 read, 10 clear referenced, 11 ranged write |
| cmd_addr | input | ADDR_W | Byte address of the frame |
| cmd_key | input | 8 | Key byte to write |
| cmd_problem | input | 1 | Issuer is in problem (unprivileged) state |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_exc | output | 2 | 00 none, 01 privileged operation, 10 addressing |
| rsp_key | output | 8 | Key read back |
| rsp_cc | output | 2 | {referenced, changed} before the clear |
| rsp_next_addr | output | ADDR_W | Address past the last frame of a ranged write |
| mem_valid | input | 1 | Sideband memory access strobe |
| mem_addr | input | ADDR_W | Sideband access byte address |
| mem_store | input | 1 | Sideband access is a store |

## Verification
The hardest situation to reach is a command and a sideband access colliding on the same frame in the same cycle. In that case the order of merging decides whether a fresh write loses a store mark, or whether a reference clear wipes out a reference that happens at the same moment. The bench drives the sideband strobe on the very edge that accepts a write, a reference clear or a read, and compares the later read against the merged value. The ranged write is driven from mid-segment, from the last frame of a segment and into the end of installed memory, so that both stop conditions are hit. An out-of-range sideband address is chosen so that dropping the top bits would alias frame 0.

// File: rtl/pgkey_pkg.sv
package pgkey_pkg;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'b00,
    OP_READ   = 2'b01,
    OP_CLRREF = 2'b10,
    OP_RANGE  = 2'b11
  } pgkey_op_e;

  typedef enum logic [1:0] {
    EXC_NONE = 2'b00,
    EXC_PRIV = 2'b01,
    EXC_ADDR = 2'b10
  } pgkey_exc_e;

  // Stored key: the byte without its always-zero bit 0.
  typedef struct packed {
    logic [3:0] acc;
    logic       fprot;
    logic       refd;
    logic       chgd;
  } pgkey_t;

  function automatic pgkey_t key_of_byte(input logic [7:0] b);
    return pgkey_t'(b[7:1]);
  endfunction

  function automatic logic [7:0] byte_of_key(input pgkey_t k);
    return {k, 1'b0};
  endfunction

  // True when a frame index is the last one of its aligned segment.
  function automatic logic seg_last(input logic [63:0] frame, input int seg_bits);
    logic [63:0] mask;
    mask = (64'd1 << seg_bits) - 64'd1;
    return (frame & mask) == mask;
  endfunction

  // Byte address of the frame following the given one.
  function automatic logic [63:0] addr_after(input logic [63:0] frame, input int page_shift);
    return (frame + 64'd1) << page_shift;
  endfunction

endpackage

// File: rtl/pgkey_mark.sv
module pgkey_mark
  import pgkey_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_FRAMES = 384
) (
  input  logic                          mem_valid,
  input  logic [ADDR_W-1:0]             mem_addr,
  input  logic                          mem_store,
  output logic                          mark_en,
  output logic [$clog2(NUM_FRAMES)-1:0] mark_idx,
  output logic                          mark_store
);
  localparam int FRAME_W = ADDR_W - PAGE_SHIFT;
  localparam int FIDX_W  = $clog2(NUM_FRAMES);

  logic [FRAME_W-1:0] mem_frame;
  logic               mem_in_range;
  logic               unused_offset;

  assign mem_frame     = mem_addr[ADDR_W-1:PAGE_SHIFT];
  assign unused_offset = ^mem_addr[PAGE_SHIFT-1:0];
  assign mem_in_range  = mem_frame < FRAME_W'(NUM_FRAMES);

  assign mark_en    = mem_valid && mem_in_range;
  assign mark_idx   = mem_frame[FIDX_W-1:0];
  assign mark_store = mem_store;

endmodule

// File: rtl/pgkey_array.sv
module pgkey_array
  import pgkey_pkg::*;
#(
  parameter int NUM_FRAMES = 384
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [$clog2(NUM_FRAMES)-1:0] wr_idx,
  input  pgkey_t                        wr_key,
  input  logic                          clr_en,
  input  logic [$clog2(NUM_FRAMES)-1:0] clr_idx,
  input  logic                          mark_en,
  input  logic [$clog2(NUM_FRAMES)-1:0] mark_idx,
  input  logic                          mark_store,
  input  logic [$clog2(NUM_FRAMES)-1:0] rd_idx,
  output pgkey_t                        rd_key
);
  localparam int FIDX_W = $clog2(NUM_FRAMES);

  pgkey_t keys [NUM_FRAMES];
  pgkey_t nxt  [NUM_FRAMES];

  // Merge order per frame: command write, then reference clear, then sideband marks.
  always_comb begin
    for (int i = 0; i < NUM_FRAMES; i++) begin
      nxt[i] = keys[i];
      if (wr_en && wr_idx == FIDX_W'(i)) nxt[i] = wr_key;
      if (clr_en && clr_idx == FIDX_W'(i)) nxt[i].refd = 1'b0;
      if (mark_en && mark_idx == FIDX_W'(i)) begin
        nxt[i].refd = 1'b1;
        if (mark_store) nxt[i].chgd = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_FRAMES; i++) begin
      if (!rst_n) keys[i] <= '0;
      else        keys[i] <= nxt[i];
    end
  end

  always_comb begin
    rd_key = '0;
    if (int'(rd_idx) < NUM_FRAMES) rd_key = keys[rd_idx];
  end

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_key_chk
    // R4: a changed flag only drops when a command wrote the frame
    p_chg_falls_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(keys[g].chgd) |-> $past(wr_en && wr_idx == FIDX_W'(g)));
    // R5: a referenced flag only drops by a write or a reference clear
    p_ref_falls_by_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(keys[g].refd) |->
        $past((wr_en && wr_idx == FIDX_W'(g)) || (clr_en && clr_idx == FIDX_W'(g))));
  end

endmodule

// File: rtl/pgkey_seq.sv
module pgkey_seq
  import pgkey_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PAGE_SHIFT = 12,
  parameter int SEG_SHIFT  = 20,
  parameter int NUM_FRAMES = 384
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  output logic                          cmd_ready,
  input  logic [1:0]                    cmd_op,
  input  logic [ADDR_W-1:0]             cmd_addr,
  input  logic [7:0]                    cmd_key,
  input  logic                          cmd_problem,
  input  pgkey_t                        rd_key,
  output logic [$clog2(NUM_FRAMES)-1:0] rd_idx,
  output logic                          wr_en,
  output logic [$clog2(NUM_FRAMES)-1:0] wr_idx,
  output pgkey_t                        wr_key,
  output logic                          clr_en,
  output logic [$clog2(NUM_FRAMES)-1:0] clr_idx,
  output logic                          rsp_valid,
  output logic [1:0]                    rsp_exc,
  output logic [7:0]                    rsp_key,
  output logic [1:0]                    rsp_cc,
  output logic [ADDR_W-1:0]             rsp_next_addr
);
  localparam int FRAME_W  = ADDR_W - PAGE_SHIFT;
  localparam int FIDX_W   = $clog2(NUM_FRAMES);
  localparam int SEG_BITS = SEG_SHIFT - PAGE_SHIFT;

  typedef enum logic {S_IDLE, S_WALK} seq_state_e;

  seq_state_e         state;
  logic [FIDX_W-1:0]  walk_idx;
  pgkey_t             walk_key;

  logic [FRAME_W-1:0] cmd_frame;
  logic [FIDX_W-1:0]  cmd_idx;
  logic               cmd_in_mem;
  logic               accept;
  logic               exc_priv;
  logic               exc_addr;
  logic               go;
  logic               go_write;
  logic               go_read;
  logic               go_clr;
  logic               go_range;
  logic               walk_last;
  logic               walk_done;
  logic               unused_offset;

  assign cmd_frame     = cmd_addr[ADDR_W-1:PAGE_SHIFT];
  assign cmd_idx       = cmd_frame[FIDX_W-1:0];
  assign unused_offset = ^cmd_addr[PAGE_SHIFT-1:0];
  assign cmd_in_mem    = cmd_frame < FRAME_W'(NUM_FRAMES);

  assign cmd_ready = (state == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign exc_priv  = accept && cmd_problem;
  assign exc_addr  = accept && !cmd_problem && !cmd_in_mem;
  assign go        = accept && !cmd_problem && cmd_in_mem;
  assign go_write  = go && (cmd_op == OP_WRITE);
  assign go_read   = go && (cmd_op == OP_READ);
  assign go_clr    = go && (cmd_op == OP_CLRREF);
  assign go_range  = go && (cmd_op == OP_RANGE);

  assign walk_last = seg_last(64'(walk_idx), SEG_BITS) ||
                     (walk_idx == FIDX_W'(NUM_FRAMES - 1));
  assign walk_done = (state == S_WALK) && walk_last;

  // Array ports
  assign rd_idx  = cmd_idx;
  assign clr_en  = go_clr;
  assign clr_idx = cmd_idx;
  assign wr_en   = go_write || (state == S_WALK);
  assign wr_idx  = (state == S_WALK) ? walk_idx : cmd_idx;
  assign wr_key  = (state == S_WALK) ? walk_key : key_of_byte(cmd_key);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      walk_idx <= '0;
      walk_key <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (go_range) begin
            state    <= S_WALK;
            walk_idx <= cmd_idx;
            walk_key <= key_of_byte(cmd_key);
          end
        end
        S_WALK: begin
          if (walk_last) state <= S_IDLE;
          else           walk_idx <= walk_idx + FIDX_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_exc       <= EXC_NONE;
      rsp_key       <= '0;
      rsp_cc        <= '0;
      rsp_next_addr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept && !go_range) begin
        rsp_valid     <= 1'b1;
        rsp_exc       <= exc_priv ? EXC_PRIV : (exc_addr ? EXC_ADDR : EXC_NONE);
        rsp_key       <= go_read ? byte_of_key(rd_key) : 8'h00;
        rsp_cc        <= go_clr ? {rd_key.refd, rd_key.chgd} : 2'b00;
        rsp_next_addr <= '0;
      end else if (walk_done) begin
        rsp_valid     <= 1'b1;
        rsp_exc       <= EXC_NONE;
        rsp_key       <= 8'h00;
        rsp_cc        <= 2'b00;
        rsp_next_addr <= ADDR_W'(addr_after(64'(walk_idx), PAGE_SHIFT));
      end
    end
  end

  // R6: the walk advances by one frame each cycle until it stops
  p_walk_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WALK && !walk_last) |=>
      (state == S_WALK && walk_idx == $past(walk_idx) + FIDX_W'(1)));
  // R7: a problem-state command is answered with the privileged-operation code
  p_priv_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_problem) |=> (rsp_valid && rsp_exc == EXC_PRIV && rsp_cc == 2'b00));
  // R8: no write strobe reaches the array while an address is being refused
  p_addr_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_addr |-> (state == S_IDLE && !go_write));

endmodule

// File: rtl/pgkey_ctrl.sv
module pgkey_ctrl
  import pgkey_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PAGE_SHIFT = 12,
  parameter int SEG_SHIFT  = 20,
  parameter int NUM_FRAMES = 384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_key,
  input  logic              cmd_problem,
  output logic              rsp_valid,
  output logic [1:0]        rsp_exc,
  output logic [7:0]        rsp_key,
  output logic [1:0]        rsp_cc,
  output logic [ADDR_W-1:0] rsp_next_addr,
  input  logic              mem_valid,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_store
);
  localparam int FIDX_W = $clog2(NUM_FRAMES);

  pgkey_t            rd_key;
  logic [FIDX_W-1:0] rd_idx;
  logic              wr_en;
  logic [FIDX_W-1:0] wr_idx;
  pgkey_t            wr_key;
  logic              clr_en;
  logic [FIDX_W-1:0] clr_idx;
  logic              mark_en;
  logic [FIDX_W-1:0] mark_idx;
  logic              mark_store;

  pgkey_seq #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
    .SEG_SHIFT(SEG_SHIFT), .NUM_FRAMES(NUM_FRAMES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_key(cmd_key), .cmd_problem(cmd_problem),
    .rd_key(rd_key), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_key(wr_key),
    .clr_en(clr_en), .clr_idx(clr_idx),
    .rsp_valid(rsp_valid), .rsp_exc(rsp_exc), .rsp_key(rsp_key),
    .rsp_cc(rsp_cc), .rsp_next_addr(rsp_next_addr)
  );

  pgkey_mark #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .NUM_FRAMES(NUM_FRAMES)
  ) u_mark (
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_store(mem_store),
    .mark_en(mark_en), .mark_idx(mark_idx), .mark_store(mark_store)
  );

  pgkey_array #(
    .NUM_FRAMES(NUM_FRAMES)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_key(wr_key),
    .clr_en(clr_en), .clr_idx(clr_idx),
    .mark_en(mark_en), .mark_idx(mark_idx), .mark_store(mark_store),
    .rd_idx(rd_idx), .rd_key(rd_key)
  );

  // R10: a single-step command is answered on the next cycle
  p_single_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op != OP_RANGE) |=> rsp_valid);
  // R6: returned continuation addresses are frame aligned
  p_next_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_next_addr[PAGE_SHIFT-1:0] == '0));
  // R2: bit 0 of a key read back is always zero
  p_key_bit0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_key[0] == 1'b0));

endmodule

// File: tb/pgkey_ctrl_test.sv
module pgkey_ctrl_test;
  localparam int AW = 24;
  localparam int PS = 12;
  localparam int SS = 20;
  localparam int NF = 384;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'b00;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_key = 8'h00;
  logic          cmd_problem = 1'b0;
  logic          rsp_valid;
  logic [1:0]    rsp_exc;
  logic [7:0]    rsp_key;
  logic [1:0]    rsp_cc;
  logic [AW-1:0] rsp_next_addr;
  logic          mem_valid = 1'b0;
  logic [AW-1:0] mem_addr = '0;
  logic          mem_store = 1'b0;

  pgkey_ctrl #(.ADDR_W(AW), .PAGE_SHIFT(PS), .SEG_SHIFT(SS), .NUM_FRAMES(NF)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_key(cmd_key), .cmd_problem(cmd_problem),
    .rsp_valid(rsp_valid), .rsp_exc(rsp_exc), .rsp_key(rsp_key), .rsp_cc(rsp_cc),
    .rsp_next_addr(rsp_next_addr), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_store(mem_store)
  );

  always #5 clk = ~clk;

  int         total = 0;
  int         bad = 0;
  bit         finished = 1'b0;
  logic [7:0] mdl [NF];

  logic [7:0]    r_key;
  logic [1:0]    r_cc;
  logic [1:0]    r_exc;
  logic [AW-1:0] r_next;
  int            r_cycles;
  logic          r_ready;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Issue one command, optionally with a sideband access in the accepting cycle.
  task automatic issue(input logic [1:0] op, input logic [AW-1:0] addr, input logic [7:0] key,
                       input logic prob, input logic mv, input logic [AW-1:0] maddr,
                       input logic mst);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_key = key; cmd_problem = prob;
    mem_valid = mv; mem_addr = maddr; mem_store = mst;
    @(negedge clk);
    cmd_valid = 1'b0; mem_valid = 1'b0; mem_store = 1'b0; cmd_problem = 1'b0;
    r_ready = cmd_ready;
    r_cycles = 1;
    while (!rsp_valid && r_cycles < 1000) begin
      @(negedge clk);
      r_cycles++;
    end
    r_key = rsp_key; r_cc = rsp_cc; r_exc = rsp_exc; r_next = rsp_next_addr;
  endtask

  task automatic cmd(input logic [1:0] op, input logic [AW-1:0] addr, input logic [7:0] key,
                     input logic prob);
    issue(op, addr, key, prob, 1'b0, '0, 1'b0);
  endtask

  task automatic touch(input logic [AW-1:0] addr, input logic st);
    @(negedge clk);
    mem_valid = 1'b1; mem_addr = addr; mem_store = st;
    @(negedge clk);
    mem_valid = 1'b0; mem_store = 1'b0;
  endtask

  function automatic logic [AW-1:0] fa(input int f);
    return AW'(f) << PS;
  endfunction

  task automatic read_chk(input string req, input int f);
    cmd(2'b01, fa(f) + AW'(f % 4096), 8'h00, 1'b0);
    chk(req, $sformatf("read frame %0d exc", f), 32'(r_exc), 32'd0);
    chk(req, $sformatf("read frame %0d key", f), 32'(r_key), 32'(mdl[f]));
  endtask

  task automatic range_chk(input int start, input logic [7:0] key);
    int last;
    last = ((start / 256) * 256) + 255;
    if (last > NF - 1) last = NF - 1;
    cmd(2'b11, fa(start), key, 1'b0);
    chk("R6", $sformatf("range@%0d ready low", start), 32'(r_ready), 32'd0);
    chk("R6", $sformatf("range@%0d cycles", start), 32'(r_cycles), 32'(last - start + 2));
    chk("R6", $sformatf("range@%0d next", start), 32'(r_next), 32'(fa(last + 1)));
    chk("R6", $sformatf("range@%0d exc", start), 32'(r_exc), 32'd0);
    for (int f = start; f <= last; f++) mdl[f] = key & 8'hFE;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < NF; f++) mdl[f] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1", "ready after reset", 32'(cmd_ready), 32'd1);
    read_chk("R1", 0);
    read_chk("R1", 200);
    read_chk("R1", NF - 1);
    chk("R10", "read answers in one cycle", 32'(r_cycles), 32'd1);

    // R2: write every frame, read every frame
    for (int f = 0; f < NF; f++) begin
      cmd(2'b00, fa(f), 8'((f * 29 + 17) & 255), 1'b0);
      mdl[f] = 8'((f * 29 + 17) & 254);
    end
    for (int f = 0; f < NF; f++) read_chk("R2", f);

    // R3: sideband marks over all frames
    for (int f = 0; f < NF; f++) begin
      if (f % 2 == 0) begin touch(fa(f) + AW'((f * 13) % 4096), 1'b0); mdl[f] |= 8'h04; end
      if (f % 3 == 0) begin touch(fa(f) + AW'(7), 1'b1); mdl[f] |= 8'h06; end
    end
    for (int f = 0; f < NF; f++) read_chk("R3", f);
    touch(24'h200000, 1'b1);   // aliases frame 0 if upper bits were dropped
    touch(24'h180000, 1'b1);
    cmd(2'b00, fa(0), 8'h30, 1'b0); mdl[0] = 8'h30;
    touch(24'h200000, 1'b1);
    read_chk("R3", 0);

    // R5: reference clear over all frames
    for (int f = 0; f < NF; f++) begin
      cmd(2'b10, fa(f), 8'h00, 1'b0);
      chk("R5", $sformatf("cc frame %0d", f), 32'(r_cc), 32'({mdl[f][2], mdl[f][1]}));
      mdl[f][2] = 1'b0;
    end
    for (int f = 0; f < NF; f++) read_chk("R5", f);

    // R4: changed flag after one store
    cmd(2'b00, fa(20), 8'h18, 1'b0); mdl[20] = 8'h18;
    read_chk("R4", 20);
    touch(fa(20) + AW'(100), 1'b1); mdl[20] = 8'h1E;
    read_chk("R4", 20);

    // R6: ranged writes, segment end and memory end
    range_chk(3, 8'h5F);
    read_chk("R6", 2);
    read_chk("R6", 3);
    read_chk("R6", 255);
    read_chk("R6", 256);
    range_chk(320, 8'hA8);
    read_chk("R6", 319);
    read_chk("R6", 383);
    range_chk(255, 8'h72);
    read_chk("R6", 255);

    // R8: addressing exceptions
    cmd(2'b11, 24'h180000, 8'hF0, 1'b0);
    chk("R8", "range outside exc", 32'(r_exc), 32'd2);
    chk("R8", "range outside next", 32'(r_next), 32'd0);
    chk("R8", "range outside cycles", 32'(r_cycles), 32'd1);
    read_chk("R8", 0);
    read_chk("R8", 383);
    cmd(2'b00, 24'h200000, 8'hF0, 1'b0);
    chk("R8", "write outside exc", 32'(r_exc), 32'd2);
    read_chk("R8", 0);
    cmd(2'b01, 24'hFFF000, 8'h00, 1'b0);
    chk("R8", "read outside exc", 32'(r_exc), 32'd2);
    chk("R8", "read outside key", 32'(r_key), 32'd0);
    cmd(2'b10, 24'h180000, 8'h00, 1'b0);
    chk("R8", "clear outside exc", 32'(r_exc), 32'd2);

    // R7: privileged-operation exceptions
    touch(fa(5), 1'b0); mdl[5] |= 8'h04;
    cmd(2'b00, fa(5), 8'hF0, 1'b1);
    chk("R7", "write problem exc", 32'(r_exc), 32'd1);
    read_chk("R7", 5);
    cmd(2'b10, fa(5), 8'h00, 1'b1);
    chk("R7", "clear problem exc", 32'(r_exc), 32'd1);
    chk("R7", "clear problem cc", 32'(r_cc), 32'd0);
    read_chk("R7", 5);
    cmd(2'b01, fa(5), 8'h00, 1'b1);
    chk("R7", "read problem exc", 32'(r_exc), 32'd1);
    chk("R7", "read problem key", 32'(r_key), 32'd0);
    cmd(2'b11, fa(5), 8'hF0, 1'b1);
    chk("R7", "range problem exc", 32'(r_exc), 32'd1);
    chk("R7", "range problem cycles", 32'(r_cycles), 32'd1);
    read_chk("R7", 6);
    cmd(2'b00, 24'h200000, 8'hF0, 1'b1);
    chk("R7", "problem beats addressing", 32'(r_exc), 32'd1);
    read_chk("R7", 0);

    // R9 / R10: same-cycle collisions
    issue(2'b00, fa(10), 8'h30, 1'b0, 1'b1, fa(10) + AW'(4), 1'b1);
    mdl[10] = 8'h36;
    read_chk("R9", 10);
    issue(2'b10, fa(10), 8'h00, 1'b0, 1'b1, fa(10), 1'b0);
    chk("R9", "clear with fetch cc", 32'(r_cc), 32'd3);
    read_chk("R9", 10);
    cmd(2'b00, fa(11), 8'h40, 1'b0); mdl[11] = 8'h40;
    issue(2'b01, fa(11), 8'h00, 1'b0, 1'b1, fa(11), 1'b1);
    chk("R10", "read sees pre-mark key", 32'(r_key), 32'h40);
    mdl[11] = 8'h46;
    read_chk("R10", 11);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule